// File: doc/BRIEF.md
# SPI Port-Expander Register Reader

This block is a clocked SPI master that fetches one 8-bit register from a port-expander device on a shared SPI bus. A one-cycle start pulse carries a 3-bit device hardware address and an 8-bit register address. The block then drives chip select low and sends a 16-bit command, most significant bit first. The first byte is the fixed opcode nibble `0100`, then the hardware address, then a read flag of 1. The second byte is the register address.

Without releasing chip select, it clocks eight more SCK periods and shifts the reply from MISO into an output register. It then raises chip select and reports the byte with a one-cycle done strobe.

SCK idles low (SPI mode 0) and is derived from the system clock by the even parameter `CLK_DIV` (at least 4). MOSI changes only on falling SCK edges, and MISO is taken on rising SCK edges. Everything runs in one clock domain with a synchronous active-high reset.

Top module: `spi_expander_reader`

## Requirements
- R1: The first command byte on MOSI is `0100`, then `hw_addr[2:0]`, then a 1, sent MSB first, one bit per rising SCK edge.
- R2: The register address follows as bits 9 to 16 of the frame, MSB first, with no gap. MOSI is 0 for the 8 data-phase bits, so the 24 bits seen on rising SCK edges are `{4'b0100, hw_addr, 1'b1, reg_addr, 8'h00}`.
- R3: The 8 MISO bits taken on rising SCK edges 17 to 24 form `rd_data`, first bit in bit 7. `rd_data` is updated in the same cycle as `done`. `done` lasts exactly one system clock, and `rd_data` holds its value otherwise.
- R4: Chip select is low for the whole transaction and produces exactly 24 rising SCK edges. SCK is high only while chip select is low.
- R5: MOSI never changes while SCK is high, or in the cycle SCK rises.
- R6: Each SCK half-period lasts `CLK_DIV/2` system clocks. The first rising edge follows chip select falling by `CLK_DIV/2` clocks, and chip select rises `CLK_DIV/2` clocks after the last falling edge. Chip select is low for 49·`CLK_DIV/2` clocks in total.
- R7: `busy` is high from the cycle after the start pulse until the cycle `done` rises, when it is low. Start pulses while `busy` is high are ignored.
- R8: Between transactions, chip select is high, and SCK and MOSI are low.
- R9: A synchronous reset, even in mid-transaction, returns the block to idle with chip select high, SCK and MOSI low, `busy` and `done` low and `rd_data` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a read |
| hw_addr | input | 3 | Device hardware address placed in the opcode byte |
| reg_addr | input | 8 | Register to read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle strobe: `rd_data` is valid |
| rd_data | output | 8 | Byte read from the device |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial command output |
| spi_miso | input | 1 | Serial reply input |

## Verification
The block's results are due at these times, counted from the clock edge that accepts start:
- Chip select falls at that edge.
- The first SCK rise comes `CLK_DIV/2` clocks later.
- Chip select rises, `done` pulses and `rd_data` updates together, 49·`CLK_DIV/2` clocks after the accepting edge.

The bench samples every output on the falling system clock edge and counts samples from the first one after start. It can therefore compare the first SCK-high sample index, the chip-select-low count and the position of `done` with exact values.

A device model records MOSI on each rising SCK edge and drives reply bits on falling SCK edges. The command frame and returned byte are therefore checked against the protocol and not against internal state. Monitors running on every sample catch any MOSI change while SCK is high and any non-idle line level between transactions.

// File: rtl/spi_expander_reader.sv
module spi_expander_reader #(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] hw_addr,
  input  logic [7:0] reg_addr,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int HALF      = CLK_DIV / 2;
  localparam int TW        = (HALF > 2) ? $clog2(HALF) : 1;
  localparam int CMD_BITS  = 16;
  localparam int DATA_BITS = 8;
  localparam int TOT_BITS  = CMD_BITS + DATA_BITS;
  localparam int BW        = $clog2(TOT_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_TAIL} state_t;

  state_t                 st;
  logic [TW-1:0]          tmr;
  logic [BW-1:0]          bitn;
  logic [TOT_BITS-1:0]    tx;
  logic [DATA_BITS-1:0]   rx;
  logic [TOT_BITS-1:0]    frame;

  wire tick = (tmr == TW'(HALF - 1));
  assign frame = {4'b0100, hw_addr, 1'b1, reg_addr, {DATA_BITS{1'b0}}};
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      tmr      <= '0;
      bitn     <= '0;
      tx       <= '0;
      rx       <= '0;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_mosi <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st       <= S_SETUP;
            spi_cs_n <= 1'b0;
            tmr      <= '0;
            bitn     <= '0;
            tx       <= frame;
            spi_mosi <= frame[TOT_BITS-1];
          end
        end
        S_SETUP: begin
          if (tick) begin
            tmr     <= '0;
            spi_sck <= 1'b1;
            st      <= S_SHIFT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            tmr <= '0;
            if (spi_sck) begin
              spi_sck <= 1'b0;
              if (bitn == BW'(TOT_BITS - 1)) begin
                st       <= S_TAIL;
                spi_mosi <= 1'b0;
              end else begin
                bitn     <= bitn + 1'b1;
                tx       <= tx << 1;
                spi_mosi <= tx[TOT_BITS-2];
              end
            end else begin
              spi_sck <= 1'b1;
              if (bitn >= BW'(CMD_BITS))
                rx <= {rx[DATA_BITS-2:0], spi_miso};
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            tmr      <= '0;
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            rd_data  <= rx;
            st       <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end

  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n); // R4

  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    done |-> (spi_cs_n && !busy)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(rd_data)); // R3

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spi_cs_n && !spi_sck && !spi_mosi)); // R8

endmodule

// File: tb/tb_spi_expander_reader.sv
module tb_spi_expander_reader;
  localparam int CLK_DIV = 6;
  localparam int HALF = CLK_DIV / 2;

  logic clk = 0, rst = 1, start = 0;
  logic [2:0] hw_addr = '0;
  logic [7:0] reg_addr = '0;
  logic busy, done, spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 0;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  always #2.5 clk = ~clk;

  spi_expander_reader #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst(rst), .start(start), .hw_addr(hw_addr), .reg_addr(reg_addr),
    .busy(busy), .done(done), .rd_data(rd_data), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // device model
  logic [23:0] cap;
  logic [7:0]  reply;
  int nbits;
  always @(negedge spi_cs_n) begin cap = '0; nbits = 0; spi_miso = 0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin cap = {cap[22:0], spi_mosi}; nbits++; end
  always @(negedge spi_sck) if (!spi_cs_n && nbits >= 16 && nbits < 24) spi_miso = reply[23 - nbits];

  // line monitors
  int mosi_viol = 0, idle_viol = 0;
  logic prev_sck = 0, prev_mosi = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_sck && prev_sck && spi_mosi !== prev_mosi) mosi_viol++;
      if (spi_cs_n && (spi_sck || spi_mosi)) idle_viol++;
    end
    prev_sck = spi_sck; prev_mosi = spi_mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam logic [18:0] VEC [6] = '{
    {3'd0, 8'h13, 8'hA5}, {3'd7, 8'h12, 8'h5A}, {3'd5, 8'hFF, 8'h00},
    {3'd2, 8'h00, 8'hFF}, {3'd3, 8'h0D, 8'h81}, {3'd6, 8'hA0, 8'h3C}};

  task automatic run(input logic [2:0] hw, input logic [7:0] rg, input logic [7:0] rep, input bit poke);
    int lowcnt = 0, first = -1, guard = 0, busy_bad = 0;
    reply = rep;
    @(negedge clk); start = 1; hw_addr = hw; reg_addr = rg;
    @(negedge clk); start = 0;
    do begin
      if (!spi_cs_n) lowcnt++;
      if (!busy) busy_bad++;
      if (spi_sck && first < 0) first = lowcnt;
      if (poke && lowcnt == 20) begin start = 1; hw_addr = ~hw; reg_addr = ~rg; end
      else start = 0;
      @(negedge clk); guard++;
    end while (!done && guard < 2000);
    if (guard >= 2000) chk(0, "watchdog", guard, 0);
    chk(cap[23:16] == {4'b0100, hw, 1'b1}, "R1 opcode byte", cap[23:16], {4'b0100, hw, 1'b1});
    chk(cap[15:0] == {rg, 8'h00}, "R2 reg addr and data-phase MOSI", cap[15:0], {rg, 8'h00});
    chk(rd_data == rep, "R3 read byte", rd_data, rep);
    chk(nbits == 24 && spi_cs_n, "R4 rising SCK count", nbits, 24);
    chk(lowcnt == 49 * HALF, "R6 cs low length", lowcnt, 49 * HALF);
    chk(first == HALF + 1, "R6 cs-to-first-edge", first, HALF + 1);
    chk(busy_bad == 0 && !busy, "R7 busy span", busy_bad, 0);
    @(negedge clk);
    chk(!done && rd_data == rep, "R3 done one cycle, data held", {done, rd_data}, {1'b0, rep});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !spi_mosi && !busy && !done && rd_data == 0,
        "R9 reset state", {spi_cs_n, spi_sck, spi_mosi, busy, done}, 5'b10000);
    rst = 0;
    for (int i = 0; i < 6; i++)
      run(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // start while busy is ignored (R7)
    run(3'd4, 8'h05, 8'hC3, 1'b1);
    repeat (10) @(negedge clk);
    chk(spi_cs_n && !busy, "R7 start while busy ignored", busy, 0);

    // reset mid-transaction (R9)
    reply = 8'h77;
    @(negedge clk); start = 1; hw_addr = 3'd1; reg_addr = 8'h44;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    chk(spi_cs_n && !spi_sck && !spi_mosi && !busy && !done && rd_data == 0,
        "R9 reset mid-transaction", {spi_cs_n, spi_sck, spi_mosi, busy, done, rd_data}, {5'b10000, 8'h00});
    repeat (5) @(negedge clk);
    chk(spi_cs_n && !busy, "R9 stays idle after reset", busy, 0);
    run(3'd1, 8'h44, 8'h77, 1'b0);

    chk(mosi_viol == 0, "R5 MOSI steady while SCK high", mosi_viol, 0);
    chk(idle_viol == 0, "R8 idle line levels", idle_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule